// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block carries out partial-word "left" and "right" loads and stores on a little-endian bus whose words are 32 bits wide. A request gives the operation, a byte address, the current contents of the CPU register involved and a destination tag. The block always reads the word-aligned memory word that holds the addressed byte. It then merges byte lanes of that word with the register value. A mask is chosen by the two low address bits, and the shift is eight times those bits.

For loads, the merged value is sent out on a one-cycle write-back strobe, with the tag, to the register file's delayed write port. For stores, the block writes the merged word back to the same aligned address. This is a read-modify-write, so no byte enables are used. A small controller runs the handshakes on a valid/ready request channel and a read-response channel. It accepts one request at a time.

The register operand must be the register's raw current contents, not a value forwarded from an earlier load that is still pending.

Top module: `uwm_top`

## Requirements
- R1: Every memory request (read or write) carries the request address with its two low bits forced to zero.
- R2: Operation code 2'b00 is load-left. With s = 8 × addr[1:0], the result is (reg AND (0x00FFFFFF >> s)) OR (mem << (24 − s)). Bits shifted out are lost, with no wraparound.
- R3: Operation code 2'b01 is load-right. The result is (reg AND (0xFFFFFF00 << (24 − s))) OR (mem >> s).
- R4: Operation code 2'b10 is store-left. The word written is (mem AND (0xFFFFFF00 << s)) OR (reg >> (24 − s)).
- R5: Operation code 2'b11 is store-right. The word written is (mem AND (0x00FFFFFF >> (24 − s))) OR (reg << s).
- R6: A load issues exactly one read and no write. One cycle after the read data arrives, it raises `wb_valid` for exactly one cycle, with the merged result on `wb_data` and the request's tag on `wb_tag`.
- R7: A store issues a read, waits for the data, then issues a write of the merged word to the same aligned address. It raises `st_done` for exactly one cycle, in the cycle after the write is accepted.
- R8: `req_ready` is high only while the block is idle. A `req_valid` presented while the block is busy is ignored: it starts no memory access and produces no result.
- R9: After reset the block is idle: `req_ready` is high, and `mem_req_valid`, `wb_valid` and `st_done` are low.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request (address, write flag, write data) holds steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| req_addr | input | 32 | Byte address |
| req_reg | input | 32 | Raw current register contents |
| req_tag | input | 5 | Destination register index for loads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word-aligned address |
| mem_req_wdata | output | 32 | Merged store word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | 32 | Read data |
| wb_valid | output | 1 | Delayed register write strobe |
| wb_tag | output | 5 | Destination register index |
| wb_data | output | 32 | Merged load result |
| st_done | output | 1 | Store completed |

## Verification
The assertions assume that the memory side answers each accepted read with exactly one `mem_rsp_valid` pulse, some cycles later. They also assume that it never sends a response when no read is outstanding, and that `mem_req_ready` may stall for any number of cycles. The bench memory model keeps to this. It schedules one response per read handshake, with a latency that varies between one and three cycles, and it holds off ready on a repeating pattern. The request side sends requests only when it sees `req_ready`. The busy-time `req_valid` pulses are deliberately presented outside that rule, to exercise R8.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  typedef enum logic [1:0] {
    UWM_LDL = 2'b00,
    UWM_LDR = 2'b01,
    UWM_STL = 2'b10,
    UWM_STR = 2'b11
  } uwm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_REQ = 3'd1,
    ST_RD_WT  = 3'd2,
    ST_LD_OUT = 3'd3,
    ST_WR_REQ = 3'd4,
    ST_FIN    = 3'd5
  } uwm_state_e;

  function automatic logic op_is_store(uwm_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_left(uwm_op_e op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/uwm_merge.sv
module uwm_merge
  import uwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  uwm_op_e                         op,
  input  logic [$clog2(DATA_W/8)-1:0]     ofs,
  input  logic [DATA_W-1:0]               reg_val,
  input  logic [DATA_W-1:0]               mem_val,
  output logic [DATA_W-1:0]               load_res,
  output logic [DATA_W-1:0]               store_word
);
  localparam int OFS_W  = $clog2(DATA_W/8);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int SH_MAX = DATA_W - 8;
  localparam logic [DATA_W-1:0] ONES   = '1;
  localparam logic [DATA_W-1:0] LO_MSK = ONES >> 8;
  localparam logic [DATA_W-1:0] HI_MSK = ONES << 8;

  logic [SH_W-1:0] sh, sh_inv;
  logic [DATA_W-1:0] ld_left, ld_right, st_left, st_right;

  always_comb begin
    sh     = SH_W'({ofs, 3'b000});
    sh_inv = SH_W'(SH_MAX) - sh;
  end

  // Shifts of a DATA_W vector zero-fill, so lanes moved out vanish.
  always_comb begin
    ld_left  = (reg_val & (LO_MSK >> sh))     | (mem_val << sh_inv);
    ld_right = (reg_val & (HI_MSK << sh_inv)) | (mem_val >> sh);
    st_left  = (mem_val & (HI_MSK << sh))     | (reg_val >> sh_inv);
    st_right = (mem_val & (LO_MSK >> sh_inv)) | (reg_val << sh);
  end

  always_comb begin
    load_res   = op_is_left(op) ? ld_left : ld_right;
    store_word = op_is_left(op) ? st_left : st_right;
  end

  // Offset 0 right-load returns the whole memory word; offset max left-load too.
  always_comb begin
    if (ofs == '1) begin
      a_r2_full_word_left: assert (ld_left == mem_val);
    end
    if (ofs == '0) begin
      a_r3_full_word_right: assert (ld_right == mem_val);
    end
  end
  logic unused_ofs;
  assign unused_ofs = ^OFS_W;
endmodule

// File: rtl/uwm_hold.sv
module uwm_hold
  import uwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_en,
  input  logic                          rsp_en,
  input  uwm_op_e                       req_op,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_reg,
  input  logic [TAG_W-1:0]              req_tag,
  input  logic [DATA_W-1:0]             rsp_data,
  output uwm_op_e                       h_op,
  output logic [$clog2(DATA_W/8)-1:0]   h_ofs,
  output logic [ADDR_W-1:0]             h_addr,
  output logic [DATA_W-1:0]             h_reg,
  output logic [TAG_W-1:0]              h_tag,
  output logic [DATA_W-1:0]             h_mem
);
  localparam int OFS_W = $clog2(DATA_W/8);

  uwm_op_e                 op_d;
  logic [OFS_W-1:0]        ofs_d;
  logic [ADDR_W-1:0]       addr_d;
  logic [DATA_W-1:0]       reg_d, mem_d;
  logic [TAG_W-1:0]        tag_d;

  always_comb begin
    op_d   = req_en ? req_op : h_op;
    ofs_d  = req_en ? req_addr[OFS_W-1:0] : h_ofs;
    addr_d = req_en ? {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : h_addr;
    reg_d  = req_en ? req_reg : h_reg;
    tag_d  = req_en ? req_tag : h_tag;
    mem_d  = rsp_en ? rsp_data : h_mem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_op   <= UWM_LDL;
      h_ofs  <= '0;
      h_addr <= '0;
      h_reg  <= '0;
      h_tag  <= '0;
      h_mem  <= '0;
    end else begin
      h_op   <= op_d;
      h_ofs  <= ofs_d;
      h_addr <= addr_d;
      h_reg  <= reg_d;
      h_tag  <= tag_d;
      h_mem  <= mem_d;
    end
  end
endmodule

// File: rtl/uwm_ctrl.sv
module uwm_ctrl
  import uwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic is_store,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic req_take,
  output logic rsp_take,
  output logic mem_req_valid,
  output logic mem_req_we,
  output logic wb_valid,
  output logic st_done
);
  uwm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid)     state_d = ST_RD_REQ;
      ST_RD_REQ: if (mem_req_ready) state_d = ST_RD_WT;
      ST_RD_WT:  if (mem_rsp_valid) state_d = is_store ? ST_WR_REQ : ST_LD_OUT;
      ST_LD_OUT:                    state_d = ST_IDLE;
      ST_WR_REQ: if (mem_req_ready) state_d = ST_FIN;
      ST_FIN:                       state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    req_take      = req_ready && req_valid;
    rsp_take      = (state_q == ST_RD_WT) && mem_rsp_valid;
    mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    mem_req_we    = (state_q == ST_WR_REQ);
    wb_valid      = (state_q == ST_LD_OUT);
    st_done       = (state_q == ST_FIN);
  end

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  a_r6_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  a_r6_wb_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_rsp_valid));
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> $past(mem_req_valid && mem_req_ready && mem_req_we));
  a_r7_write_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_we) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/uwm_top.sv
module uwm_top
  import uwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic              st_done
);
  localparam int OFS_W = $clog2(DATA_W/8);

  logic              req_take, rsp_take;
  uwm_op_e           h_op;
  logic [OFS_W-1:0]  h_ofs;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_reg, h_mem, ld_res, st_word;

  uwm_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .is_store      (op_is_store(h_op)),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .req_ready     (req_ready),
    .req_take      (req_take),
    .rsp_take      (rsp_take),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .wb_valid      (wb_valid),
    .st_done       (st_done)
  );

  uwm_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_en   (req_take),
    .rsp_en   (rsp_take),
    .req_op   (uwm_op_e'(req_op)),
    .req_addr (req_addr),
    .req_reg  (req_reg),
    .req_tag  (req_tag),
    .rsp_data (mem_rsp_rdata),
    .h_op     (h_op),
    .h_ofs    (h_ofs),
    .h_addr   (h_addr),
    .h_reg    (h_reg),
    .h_tag    (wb_tag),
    .h_mem    (h_mem)
  );

  uwm_merge #(.DATA_W(DATA_W)) u_merge (
    .op         (h_op),
    .ofs        (h_ofs),
    .reg_val    (h_reg),
    .mem_val    (h_mem),
    .load_res   (ld_res),
    .store_word (st_word)
  );

  always_comb begin
    mem_req_addr  = h_addr;
    mem_req_wdata = st_word;
    wb_data       = ld_res;
  end

  a_r1_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (mem_req_addr[OFS_W-1:0] == '0));
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  a_r6_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_we && mem_req_valid) |-> op_is_store(h_op));
endmodule

// File: tb/uwm_top_tb.sv
module uwm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_reg = '0;
  logic [4:0]  req_tag = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        wb_valid, st_done;
  logic [4:0]  wb_tag;
  logic [31:0] wb_data;

  always #10 clk = ~clk;

  uwm_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .req_tag(req_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .st_done(st_done)
  );

  typedef struct {
    logic [1:0]  op;
    logic [31:0] exp;
    logic [3:0]  idx;
    logic [4:0]  tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] mem [16];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pend = 0;
  int nrd = 0;
  int nwr = 0;
  bit done_run = 0;

  function automatic logic [31:0] model(logic [1:0] op, logic [1:0] ofs,
                                        logic [31:0] r, logic [31:0] m);
    int s;
    s = 8 * ofs;
    case (op)
      2'b00: return (r & (32'h00FFFFFF >> s)) | (m << (24 - s));
      2'b01: return (r & (32'hFFFFFF00 << (24 - s))) | (m >> s);
      2'b10: return (m & (32'hFFFFFF00 << s)) | (r >> (24 - s));
      default: return (m & (32'h00FFFFFF >> (24 - s))) | (r << s);
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model and monitor share one process so updates precede checks.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem[mem_req_addr[5:2]];
        end
      end
      mem_req_ready = (cyc % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        check(mem_req_addr[1:0] == 2'b00, "R1", {30'd0, mem_req_addr[1:0]}, 32'd0);
        if (mem_req_we) begin
          nwr++;
          if (sb.size() == 0 || !sb[0].op[1])
            check(1'b0, "R6", 32'd1, 32'd0);
          else begin
            check(mem_req_addr[5:2] == sb[0].idx, "R7", {28'd0, mem_req_addr[5:2]}, {28'd0, sb[0].idx});
            check(mem_req_wdata == sb[0].exp, sb[0].op[0] ? "R5" : "R4", mem_req_wdata, sb[0].exp);
          end
          mem[mem_req_addr[5:2]] = mem_req_wdata;
        end else begin
          nrd++;
          pend = 1 + (nrd % 3);
        end
      end
      if (wb_valid) begin
        if (sb.size() == 0) check(1'b0, "R8", 32'd1, 32'd0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(!it.op[1], "R6", {30'd0, it.op}, 32'd0);
          check(wb_tag == it.tag, "R6", {27'd0, wb_tag}, {27'd0, it.tag});
          check(wb_data == it.exp, it.op[0] ? "R3" : "R2", wb_data, it.exp);
        end
      end
      if (st_done) begin
        if (sb.size() == 0) check(1'b0, "R8", 32'd1, 32'd0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(it.op[1], "R7", {30'd0, it.op}, 32'd2);
          check(mem[it.idx] == it.exp, "R7", mem[it.idx], it.exp);
        end
      end
    end
    if (cyc > 100000 && !done_run) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(logic [1:0] op, logic [3:0] idx, logic [1:0] ofs,
                       logic [31:0] r, logic [4:0] tag);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.op  = op;
    it.idx = idx;
    it.tag = tag;
    it.exp = model(op, ofs, r, mem[idx]);
    sb.push_back(it);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = 32'h0000_0100 | {26'd0, idx, ofs};
    req_reg   = r;
    req_tag   = tag;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0B1C2D3 ^ (i * 32'h01010101);
    repeat (3) @(negedge clk);
    // R9: idle state out of reset
    check(req_ready == 1'b1, "R9", {31'd0, req_ready}, 32'd1);
    check(mem_req_valid == 1'b0, "R9", {31'd0, mem_req_valid}, 32'd0);
    check(wb_valid == 1'b0 && st_done == 1'b0, "R9", {30'd0, wb_valid, st_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2..R7: every operation at every byte offset, two operand patterns
    for (int p = 0; p < 2; p++)
      for (int op = 0; op < 4; op++)
        for (int ofs = 0; ofs < 4; ofs++) begin
          drive(op[1:0], 4'((op * 4 + ofs + p) % 16), ofs[1:0],
                p == 0 ? 32'h11223344 : 32'hF0E1D2C3 + op, 5'(op * 4 + ofs + 1));
          drain();
        end
    // R8: spurious requests while a store is busy must be ignored
    begin
      int r0, w0;
      drive(2'b10, 4'd5, 2'd1, 32'hCAFEBABE, 5'd9);
      while (!req_ready) begin
        req_valid = 1'b1;
        req_op    = 2'b11;
        req_addr  = 32'h0000_0120;
        req_reg   = 32'hDEADDEAD;
        @(negedge clk);
      end
      req_valid = 1'b0;
      drain();
      r0 = nrd;
      w0 = nwr;
      repeat (10) @(negedge clk);
      check(nrd == r0 && nwr == w0, "R8", 32'(nrd + nwr), 32'(r0 + w0));
      check(sb.size() == 0, "R8", 32'(sb.size()), 32'd0);
    end
    // back-to-back mixed traffic on one word: load sees prior store
    drive(2'b11, 4'd7, 2'd2, 32'h00005566, 5'd3);
    drive(2'b01, 4'd7, 2'd2, 32'h99999999, 5'd4);
    drive(2'b00, 4'd7, 2'd0, 32'h12345678, 5'd31);
    drain();
    repeat (4) @(negedge clk);
    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule